// File: doc/BRIEF.md
# Sequential Cube Operation Sequencer

This block steers one sequential cube operation on a linear array of iterative cells. A global controller starts it with a level request; the sequencer first holds every cell state machine in its cleared position, then drives the seed of the token chain so that the first special variable picks up the active token. Each time the array reports that the token has settled, the sequencer issues one request pulse to step the cells and, in the same cycle, one write pulse so that the resulting cube is stored.

The array also reports when the token has run off the far end of the chain. In both waiting states that indication outranks the settle indication, and the sequencer then signals completion for one cycle and returns to its idle, clearing state. The first result cube and later result cubes come from separate states. A request is therefore always followed by at least one waiting cycle, even when the settle indication stays high. Combinational cube operations never raise the start input and do not pass through this block.

Every output is decoded from the state register alone. A synchronous active-low reset returns the sequencer to idle.

Top module: `seqctl_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, the sequencer enters idle. In idle, cell_clr=1 and chain_seed=0, cube_req=0, cube_wr=0, run_done=0.
- R2: In idle with run_en=0, the sequencer stays in idle and cell_clr stays 1.
- R3: In idle with run_en=1, the next cycle is the arm state: chain_seed=1, cell_clr=0, cube_req=0, run_done=0.
- R4: In the arm state, arr_last=1 leads to the finish state in the next cycle whatever arr_ready is. With neither arr_last nor arr_ready, the sequencer stays in arm.
- R5: In the arm state, arr_ready=1 with arr_last=0 leads in the next cycle to one cycle with cube_req=1 and cube_wr=1 (the first result).
- R6: In the wait state, arr_last=1 leads to finish, whatever arr_ready is. arr_ready=1 with arr_last=0 leads to one cycle of cube_req=1 and cube_wr=1. Otherwise the sequencer stays in wait, with chain_seed=1 and no request.
- R7: In finish, run_done=1 for exactly one cycle, and the next cycle is idle (cell_clr=1).
- R8: chain_seed is 1 in the arm state, the wait state and both request states, and 0 in idle and in finish.
- R9: cube_wr always equals cube_req. Neither is ever 1 together with cell_clr or run_done.
- R10: run_en has no effect outside idle. arr_ready and arr_last have no effect in idle, in finish or in the request states.
- R11: Each request cycle is followed by the wait state (chain_seed=1, cube_req=0), so that two requests are never adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Start level from the global controller |
| arr_ready | input | 1 | Token has settled in the array |
| arr_last | input | 1 | Token has passed the last cell |
| cell_clr | output | 1 | Synchronous clear for all cell state machines |
| chain_seed | output | 1 | Seed of the token chain |
| cube_req | output | 1 | Step request to the array |
| cube_wr | output | 1 | Write strobe for the result cube |
| run_done | output | 1 | One-cycle completion pulse |

## Verification
The outputs are a pure decode of the state, so a wrong state shows at the ports in the cycle right after the bad transition. It appears as a request that comes twice, comes late or is missing, a seed that drops during the operation, a missed or doubled completion pulse, or a clear that is not asserted. The stimulus mixes random levels on all inputs with directed cases in which arr_ready and arr_last are high together, in which run_en is high during the operation, and in which arr_ready stays high across several request cycles.

// File: rtl/seqctl_pkg.sv
package seqctl_pkg;

    localparam int PHASE_W = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE   = 3'd0,
        PH_ARM    = 3'd1,
        PH_FIRST  = 3'd2,
        PH_WAIT   = 3'd3,
        PH_MORE   = 3'd4,
        PH_FINISH = 3'd5
    } phase_e;

    typedef struct packed {
        phase_e phase;
    } ctl_state_t;

    typedef struct packed {
        logic clr;
        logic seed;
        logic req;
        logic wr;
        logic done;
    } ctl_out_t;

endpackage

// File: rtl/seqctl_next.sv
module seqctl_next
    import seqctl_pkg::*;
(
    input  ctl_state_t cur_i,
    input  logic       run_en_i,
    input  logic       ready_i,
    input  logic       last_i,
    output ctl_state_t nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        unique case (cur_i.phase)
            PH_IDLE: begin
                if (run_en_i) nxt_o.phase = PH_ARM;
            end
            PH_ARM: begin
                if (last_i)       nxt_o.phase = PH_FINISH;
                else if (ready_i) nxt_o.phase = PH_FIRST;
            end
            PH_FIRST: nxt_o.phase = PH_WAIT;
            PH_WAIT: begin
                if (last_i)       nxt_o.phase = PH_FINISH;
                else if (ready_i) nxt_o.phase = PH_MORE;
            end
            PH_MORE:   nxt_o.phase = PH_WAIT;
            PH_FINISH: nxt_o.phase = PH_IDLE;
            default:   nxt_o.phase = PH_IDLE;
        endcase
    end
endmodule

// File: rtl/seqctl_decode.sv
module seqctl_decode
    import seqctl_pkg::*;
(
    input  ctl_state_t cur_i,
    output ctl_out_t   out_o
);
    always_comb begin
        out_o = '0;
        unique case (cur_i.phase)
            PH_IDLE:   out_o.clr  = 1'b1;
            PH_ARM:    out_o.seed = 1'b1;
            PH_FIRST, PH_MORE: begin
                out_o.seed = 1'b1;
                out_o.req  = 1'b1;
                out_o.wr   = 1'b1;
            end
            PH_WAIT:   out_o.seed = 1'b1;
            PH_FINISH: out_o.done = 1'b1;
            default:   out_o.clr  = 1'b1;
        endcase
    end
endmodule

// File: rtl/seqctl_top.sv
module seqctl_top
    import seqctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic arr_ready,
    input  logic arr_last,
    output logic cell_clr,
    output logic chain_seed,
    output logic cube_req,
    output logic cube_wr,
    output logic run_done
);
    ctl_state_t state_q;
    ctl_state_t state_d;
    ctl_state_t step_d;
    ctl_out_t   dec_q;

    seqctl_next u_next (
        .cur_i    (state_q),
        .run_en_i (run_en),
        .ready_i  (arr_ready),
        .last_i   (arr_last),
        .nxt_o    (step_d)
    );

    always_comb begin
        state_d = step_d;
        if (!rst_n) state_d.phase = PH_IDLE;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    seqctl_decode u_dec (
        .cur_i (state_q),
        .out_o (dec_q)
    );

    assign cell_clr   = dec_q.clr;
    assign chain_seed = dec_q.seed;
    assign cube_req   = dec_q.req;
    assign cube_wr    = dec_q.wr;
    assign run_done   = dec_q.done;

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_clr && !run_en) |=> cell_clr);

    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_clr && run_en) |=> (chain_seed && !cell_clr && !cube_req));

    p_last_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_seed && !cube_req && arr_last) |=> run_done);

    p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_seed && !cube_req && arr_ready && !arr_last) |=> cube_req);

    p_done_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> (cell_clr && !run_done));

    p_one_role_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({cell_clr, chain_seed, run_done}));

    p_wr_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cube_wr == cube_req) && !(cube_req && (cell_clr || run_done)));

    p_no_back_to_back_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cube_req |=> (chain_seed && !cube_req));

endmodule

// File: tb/seqctl_top_test.sv
module seqctl_top_test;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, run_en, arr_ready, arr_last;
    logic cell_clr, chain_seed, cube_req, cube_wr, run_done;

    int checks = 0;
    int fails  = 0;
    int m_st   = 0;

    always #(PERIOD/2) clk = ~clk;

    seqctl_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .arr_ready  (arr_ready),
        .arr_last   (arr_last),
        .cell_clr   (cell_clr),
        .chain_seed (chain_seed),
        .cube_req   (cube_req),
        .cube_wr    (cube_wr),
        .run_done   (run_done)
    );

    // model states: 0 idle, 1 arm, 2 first, 3 wait, 4 more, 5 finish
    function automatic int model_next(int st, bit r, bit e, bit y, bit t);
        if (!r) return 0;
        case (st)
            0: return e ? 1 : 0;
            1: return t ? 5 : (y ? 2 : 1);
            2: return 3;
            3: return t ? 5 : (y ? 4 : 3);
            4: return 3;
            default: return 0;
        endcase
    endfunction

    // {clr, seed, req, done}
    function automatic logic [3:0] model_out(int st);
        case (st)
            0: return 4'b1000;
            1: return 4'b0100;
            2: return 4'b0110;
            3: return 4'b0100;
            4: return 4'b0110;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic string pick_tag(int st, bit r, bit e, bit y, bit t);
        if (!r) return "R1";
        if (e && st != 0) return "R10";
        if ((y || t) && (st == 0 || st == 5)) return "R10";
        case (st)
            0: return e ? "R3" : "R2";
            1: return t ? "R4" : "R5";
            3: return "R6";
            2, 4: return "R11";
            default: return "R7";
        endcase
    endfunction

    task automatic check1(string tg, string nm, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tg, nm, got, exp, $time);
        end
    endtask

    task automatic check_all(string tg);
        logic [3:0] e;
        e = model_out(m_st);
        check1(tg,   "cell_clr",   cell_clr,   e[3]);
        check1("R8", "chain_seed", chain_seed, e[2]);
        check1(tg,   "cube_req",   cube_req,   e[1]);
        check1("R9", "cube_wr",    cube_wr,    e[1]);
        check1(tg,   "run_done",   run_done,   e[0]);
    endtask

    task automatic step(bit r, bit e, bit y, bit t);
        string tg;
        rst_n = r; run_en = e; arr_ready = y; arr_last = t;
        tg = pick_tag(m_st, r, e, y, t);
        m_st = model_next(m_st, r, e, y, t);
        @(negedge clk);
        check_all(tg);
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0101));
        rst_n = 1'b0; run_en = 1'b0; arr_ready = 1'b1; arr_last = 1'b1;
        m_st = 0;
        @(negedge clk);
        check_all("R1");
        step(0, 1, 1, 1);               // R1 reset dominates
        step(1, 0, 1, 1);               // R2 idle ignores array inputs
        step(1, 0, 0, 0);               // R2
        step(1, 1, 0, 0);               // R3 start
        step(1, 0, 1, 1);               // R4 last beats ready in arm
        step(1, 1, 0, 0);               // R7 finish, run_en ignored
        step(1, 1, 0, 0);               // R3
        step(1, 1, 0, 0);               // R10 arm holds with run_en high
        step(1, 0, 1, 0);               // R5 first result
        step(1, 0, 1, 1);               // R11 request state ignores last
        step(1, 0, 1, 0);               // R6 further result
        step(1, 0, 1, 0);               // R11 back to wait despite ready
        step(1, 0, 1, 0);               // R6
        step(1, 0, 0, 0);               // R11
        step(1, 0, 0, 0);               // R6 wait holds
        step(1, 0, 1, 1);               // R6 last beats ready in wait
        step(1, 0, 0, 0);               // R7
        step(1, 1, 0, 0);
        step(0, 1, 1, 0);               // R1 reset during operation
        for (int i = 0; i < 4000; i++) begin
            bit r, e, y, t;
            r = ($urandom % 50) != 0;
            e = ($urandom % 10) < 3;
            y = ($urandom % 10) < 4;
            t = ($urandom % 10) == 0;
            step(r, e, y, t);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule